// File: doc/BRIEF.md
# Eight-Tone FSK Baseband Modulator

This block turns a serial stream of coded bits into complex baseband samples of an eight-tone frequency-shift-keyed signal. Bits arrive one per accepted handshake and are packed three at a time into a tone index. Each tone index then drives a 32-bit phase accumulator for a programmable number of output samples. A sine table inside the block converts the top ten accumulator bits into signed 12-bit cosine (I) and sine (Q) samples. The eight tones sit symmetrically about zero with a 5 kHz spacing, from -17.5 kHz up to +17.5 kHz, at a 200 kHz sample rate. One output sample is produced per clock.

A mode input selects how the phase behaves at symbol boundaries. In continuous mode the accumulator carries straight through a tone change, so the waveform never jumps. In split mode the accumulator restarts at zero on the first sample of every symbol, so the output is a sequence of separate sinusoid pieces. When a symbol ends and no complete bit group is waiting, the block emits zero samples and raises an underflow flag until bits arrive. A frame of 120 coded bits becomes 40 symbols.

Top module: `fsk8_tone_mod`

## Requirements
- R1: Three accepted bits form one tone index, with the first bit accepted as bit 2 (most significant). `out_tone` shows the index of the tone being emitted.
- R2: While a complete group waits for its symbol slot, `bit_ready` is low and no offered bit is taken. Every bit offered in that time is still sent later, in order.
- R3: Each symbol lasts exactly `sps_cfg` valid samples. A value of 0 behaves as 1.
- R4: Within a symbol, the accumulator advances each sample by step(i) = trunc((2i-7) * 5000 * 2^32 / 400000) modulo 2^32, where i is the tone index.
- R5: With p the top 10 bits of the accumulator, `out_i` equals round(2047 * cos(2*pi*p/1024)) and `out_q` equals round(2047 * sin(2*pi*p/1024)), each to within 1 LSB.
- R6: In continuous mode (`cont_phase` = 1), the first sample of a new symbol has the phase of the previous emitted sample plus that sample's step. The phase stays frozen through idle gaps. The first symbol after reset starts at phase 0.
- R7: In split mode (`cont_phase` = 0), every symbol starts at phase 0, so its first sample is exactly I = 2047 and Q = 0.
- R8: When a symbol ends and no complete group is waiting, `out_valid` is 0, I and Q are 0, and `out_underflow` is 1 until a group arrives.
- R9: During reset, `out_valid`, `out_i`, `out_q` and `out_underflow` are 0, and `bit_ready` is 1. On the first sample after reset with no input, `out_underflow` rises.
- R10: When `sps_cfg` >= 4 and a bit is offered every cycle, consecutive symbols follow with no idle sample between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one output sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A coded bit is offered on bit_data |
| bit_data | input | 1 | Coded bit value |
| bit_ready | output | 1 | The offered bit is taken at this edge |
| cont_phase | input | 1 | 1 continuous phase, 0 phase restart per symbol |
| sps_cfg | input | 16 | Samples per symbol, captured at each symbol start |
| out_valid | output | 1 | A tone sample is present on out_i/out_q |
| out_tone | output | 3 | Tone index of the current sample |
| out_i | output | 12 | Signed cosine sample |
| out_q | output | 12 | Signed sine sample |
| out_underflow | output | 1 | No symbol was available; outputs held at zero |

## Verification
The bench goes after symbol boundaries. A design that kept accumulating across a split-mode boundary would start a symbol at a phase other than I = 2047, Q = 0. A design that reset or skipped one step at a continuous-mode boundary would leave a kink that the sample-by-sample phase model catches. Idle gaps are forced in the middle of a stream, so a design that let the accumulator drift while idle, or that leaked non-zero samples while starved, shows a phase error after the gap or a non-zero idle sample. A packer with reversed bit order, or one that took bits while its group was full, produces the wrong tone sequence. The shortest symbol lengths (0 treated as 1, and the gapless minimum of 4) expose an off-by-one in the sample counter as a wrong sample count or a bubble.

// File: rtl/fsk8_pkg.sv
package fsk8_pkg;

    localparam int BITS_PER_SYM = 3;
    localparam int NUM_TONES    = 1 << BITS_PER_SYM;
    localparam int PHASE_W      = 32;
    localparam int LUT_AW       = 10;
    localparam int SAMP_W       = 12;
    localparam int AMP          = (1 << (SAMP_W - 1)) - 1;
    localparam int QTR          = 1 << (LUT_AW - 2);

    localparam longint SPACING_HZ = 5000;
    localparam longint FS_HZ      = 200000;

    // fixed-point format used only while building the sine table
    localparam int     FRAC = 28;
    localparam longint ONE  = longint'(1) << FRAC;
    localparam longint PI_Q = longint'(843314857);

    typedef logic [BITS_PER_SYM-1:0] tone_t;
    typedef logic [PHASE_W-1:0]      phase_t;
    typedef logic signed [SAMP_W-1:0] samp_t;

    typedef enum logic {
        PH_SPLIT = 1'b0,
        PH_CONT  = 1'b1
    } ph_mode_e;

    typedef struct packed {
        samp_t i;
        samp_t q;
    } iq_t;

    // Per-sample phase step of tone idx: offset (2*idx - 7) half-spacings from zero.
    function automatic phase_t tone_step(int idx);
        longint num;
        longint quo;
        num = longint'(2 * idx - (NUM_TONES - 1)) * SPACING_HZ * (longint'(1) << PHASE_W);
        quo = num / (2 * FS_HZ);
        return quo[PHASE_W-1:0];
    endfunction

    // Magnitude of sin(k * (pi/2) / QTR) scaled to AMP, k in 0..QTR.
    function automatic int quarter_sin(int k);
        longint x;
        longint x2;
        longint t;
        longint s;
        x  = (longint'(k) * PI_Q) / longint'(2 * QTR);
        x2 = (x * x) >>> FRAC;
        t  = ONE - x2 / 72;
        t  = ONE - ((x2 * t) >>> FRAC) / 42;
        t  = ONE - ((x2 * t) >>> FRAC) / 20;
        t  = ONE - ((x2 * t) >>> FRAC) / 6;
        s  = (x * t) >>> FRAC;
        return int'((s * longint'(AMP) + (ONE >>> 1)) >>> FRAC);
    endfunction

    // Signed sine over the full circle, p in 0..4*QTR-1.
    function automatic int full_sin(int p);
        int quad;
        int k;
        quad = p / QTR;
        k    = p % QTR;
        case (quad)
            0:       return quarter_sin(k);
            1:       return quarter_sin(QTR - k);
            2:       return -quarter_sin(k);
            default: return -quarter_sin(QTR - k);
        endcase
    endfunction

endpackage

// File: rtl/fsk8_bit_pack.sv
module fsk8_bit_pack
    import fsk8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_bit,
    output logic  in_ready,
    input  logic  take,
    output logic  grp_full,
    output tone_t grp_tone
);

    localparam int CNT_W = $clog2(BITS_PER_SYM + 1);

    logic [CNT_W-1:0] cnt_q;
    tone_t            shift_q;
    logic             accept;

    assign grp_full = (cnt_q == CNT_W'(BITS_PER_SYM));
    assign in_ready = !grp_full;
    assign accept   = in_valid && in_ready;
    assign grp_tone = shift_q;

    // first bit shifts furthest up and ends as the MSB
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (take) begin
            cnt_q <= '0;
        end else if (accept) begin
            cnt_q   <= cnt_q + CNT_W'(1);
            shift_q <= {shift_q[BITS_PER_SYM-2:0], in_bit};
        end
    end

endmodule

// File: rtl/fsk8_sym_timer.sv
module fsk8_sym_timer
    import fsk8_pkg::*;
#(
    parameter int SPS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_full,
    input  logic [SPS_W-1:0] sps_cfg,
    output logic             load,
    output logic             active,
    output logic             first
);

    logic [SPS_W-1:0] left_q;
    logic             active_q;
    logic             first_q;
    logic             boundary;

    assign boundary = !active_q || (left_q == '0);
    assign load     = boundary && grp_full;
    assign active   = active_q;
    assign first    = first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            left_q   <= '0;
            first_q  <= 1'b0;
        end else begin
            first_q <= load;
            if (boundary) begin
                active_q <= grp_full;
                if (grp_full) begin
                    left_q <= (sps_cfg == '0) ? '0 : sps_cfg - SPS_W'(1);
                end
            end else begin
                left_q <= left_q - SPS_W'(1);
            end
        end
    end

endmodule

// File: rtl/fsk8_phase_gen.sv
module fsk8_phase_gen
    import fsk8_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  logic     active,
    input  ph_mode_e mode,
    input  tone_t    tone_in,
    output tone_t    tone,
    output phase_t   phase,
    output phase_t   step
);

    phase_t step_tab [NUM_TONES];

    for (genvar g = 0; g < NUM_TONES; g++) begin : g_step
        assign step_tab[g] = tone_step(g);
    end

    tone_t  tone_q;
    phase_t acc_q;
    phase_t adv;

    assign step  = step_tab[tone_q];
    assign adv   = active ? acc_q + step : acc_q;
    assign tone  = tone_q;
    assign phase = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tone_q <= '0;
        end else begin
            acc_q <= (load && mode == PH_SPLIT) ? '0 : adv;
            if (load) begin
                tone_q <= tone_in;
            end
        end
    end

endmodule

// File: rtl/fsk8_sine_lut.sv
module fsk8_sine_lut
    import fsk8_pkg::*;
#(
    parameter bit FULL_TABLE = 1'b0
) (
    input  logic [LUT_AW-1:0] ph,
    output samp_t             sin_o,
    output samp_t             cos_o
);

    logic [LUT_AW-1:0] ph_c;

    assign ph_c = ph + LUT_AW'(QTR);

    if (FULL_TABLE) begin : g_full
        samp_t rom [1 << LUT_AW];
        for (genvar g = 0; g < (1 << LUT_AW); g++) begin : g_ent
            assign rom[g] = SAMP_W'(full_sin(g));
        end
        assign sin_o = rom[ph];
        assign cos_o = rom[ph_c];
    end else begin : g_qtr
        localparam int KW = LUT_AW - 2;

        logic [SAMP_W-2:0] rom [QTR + 1];
        logic [LUT_AW-1:0] pp  [2];
        samp_t             res [2];

        for (genvar g = 0; g <= QTR; g++) begin : g_ent
            assign rom[g] = (SAMP_W - 1)'(quarter_sin(g));
        end

        assign pp[0] = ph;
        assign pp[1] = ph_c;

        // bit KW mirrors the index inside the quadrant, the MSB flips the sign
        for (genvar r = 0; r < 2; r++) begin : g_rd
            logic [KW:0]       idx;
            logic [SAMP_W-2:0] mag;
            assign idx    = pp[r][KW] ? (KW + 1)'(QTR) - {1'b0, pp[r][KW-1:0]}
                                      : {1'b0, pp[r][KW-1:0]};
            assign mag    = rom[idx];
            assign res[r] = pp[r][LUT_AW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
        end

        assign sin_o = res[0];
        assign cos_o = res[1];
    end

endmodule

// File: rtl/fsk8_tone_mod.sv
module fsk8_tone_mod
    import fsk8_pkg::*;
#(
    parameter int SPS_W      = 16,
    parameter bit FULL_TABLE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bit_valid,
    input  logic                     bit_data,
    output logic                     bit_ready,
    input  logic                     cont_phase,
    input  logic [SPS_W-1:0]         sps_cfg,
    output logic                     out_valid,
    output logic [BITS_PER_SYM-1:0]  out_tone,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_underflow
);

    logic     grp_full;
    tone_t    grp_tone;
    logic     sym_load;
    logic     active;
    logic     first;
    ph_mode_e mode;
    tone_t    tone_cur;
    phase_t   phase;
    phase_t   step;
    samp_t    sin_v;
    samp_t    cos_v;
    iq_t      iq_q;
    tone_t    tone_o_q;
    logic     valid_o_q;
    logic     uflow_o_q;
    logic     sym_split_q;
    logic     split_o_q;
    logic     first_o_q;

    assign mode = cont_phase ? PH_CONT : PH_SPLIT;

    fsk8_bit_pack u_pack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (bit_valid),
        .in_bit   (bit_data),
        .in_ready (bit_ready),
        .take     (sym_load),
        .grp_full (grp_full),
        .grp_tone (grp_tone)
    );

    fsk8_sym_timer #(.SPS_W(SPS_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .grp_full (grp_full),
        .sps_cfg  (sps_cfg),
        .load     (sym_load),
        .active   (active),
        .first    (first)
    );

    fsk8_phase_gen u_phase (
        .clk     (clk),
        .rst     (rst),
        .load    (sym_load),
        .active  (active),
        .mode    (mode),
        .tone_in (grp_tone),
        .tone    (tone_cur),
        .phase   (phase),
        .step    (step)
    );

    fsk8_sine_lut #(.FULL_TABLE(FULL_TABLE)) u_lut (
        .ph    (phase[PHASE_W-1 -: LUT_AW]),
        .sin_o (sin_v),
        .cos_o (cos_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_split_q <= 1'b0;
        end else if (sym_load) begin
            sym_split_q <= (mode == PH_SPLIT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iq_q      <= '0;
            tone_o_q  <= '0;
            valid_o_q <= 1'b0;
            uflow_o_q <= 1'b0;
            split_o_q <= 1'b0;
            first_o_q <= 1'b0;
        end else begin
            iq_q.i    <= active ? cos_v : '0;
            iq_q.q    <= active ? sin_v : '0;
            tone_o_q  <= tone_cur;
            valid_o_q <= active;
            uflow_o_q <= !active;
            split_o_q <= sym_split_q;
            first_o_q <= first;
        end
    end

    assign out_valid     = valid_o_q;
    assign out_tone      = tone_o_q;
    assign out_i         = iq_q.i;
    assign out_q         = iq_q.q;
    assign out_underflow = uflow_o_q;

endmodule

// File: rtl/fsk8_tone_mod_chk.sv
module fsk8_tone_mod_chk
    import fsk8_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     bit_ready,
    input logic                     cont_phase,
    input logic                     out_valid,
    input logic [BITS_PER_SYM-1:0]  out_tone,
    input logic signed [SAMP_W-1:0] out_i,
    input logic signed [SAMP_W-1:0] out_q,
    input logic                     out_underflow,
    input logic                     sym_load,
    input logic                     active,
    input logic [PHASE_W-1:0]       phase,
    input logic [PHASE_W-1:0]       step,
    input logic                     first_o_q,
    input logic                     split_o_q
);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_underflow |-> (out_i == 0 && out_q == 0 && !out_valid));

    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_ready && !sym_load) |=> !bit_ready);

    // R4
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !sym_load) |=> (phase == $past(phase) + $past(step)));

    // R6
    cont_join_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_load && active && cont_phase) |=> (phase == $past(phase) + $past(step)));

    // R7
    split_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sym_load && !cont_phase) |=> (phase == '0));

    // R7
    split_start_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && first_o_q && split_o_q) |-> (out_i == AMP && out_q == 0));

    // R3
    tone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid) && !first_o_q) |-> (out_tone == $past(out_tone)));

endmodule

bind fsk8_tone_mod fsk8_tone_mod_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_ready     (bit_ready),
    .cont_phase    (cont_phase),
    .out_valid     (out_valid),
    .out_tone      (out_tone),
    .out_i         (out_i),
    .out_q         (out_q),
    .out_underflow (out_underflow),
    .sym_load      (sym_load),
    .active        (active),
    .phase         (phase),
    .step          (step),
    .first_o_q     (first_o_q),
    .split_o_q     (split_o_q)
);

// File: tb/fsk8_tone_mod_tb.sv
module fsk8_tone_mod_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic        bit_ready;
    logic        cont_phase = 1'b1;
    logic [15:0] sps_cfg = 16'd4;
    logic        out_valid;
    logic [2:0]  out_tone;
    logic signed [11:0] out_i;
    logic signed [11:0] out_q;
    logic        out_underflow;

    always #4 clk = ~clk;

    fsk8_tone_mod u_dut (
        .clk           (clk),
        .rst           (rst),
        .bit_valid     (bit_valid),
        .bit_data      (bit_data),
        .bit_ready     (bit_ready),
        .cont_phase    (cont_phase),
        .sps_cfg       (sps_cfg),
        .out_valid     (out_valid),
        .out_tone      (out_tone),
        .out_i         (out_i),
        .out_q         (out_q),
        .out_underflow (out_underflow)
    );

    int checks = 0;
    int errors = 0;
    int ready_low_seen = 0;

    localparam real PI = 3.14159265358979;

    logic bit_buf [0:511];
    int   syms    [0:127];
    int   nsyms = 0;

    bit   cap_on = 1'b0;
    int   cap_n  = 0;
    logic cap_v [0:2047];
    int   cap_t [0:2047];
    int   cap_i [0:2047];
    int   cap_q [0:2047];
    logic cap_u [0:2047];

    always @(negedge clk) begin
        if (cap_on && cap_n < 2048) begin
            cap_v[cap_n] = out_valid;
            cap_t[cap_n] = int'(out_tone);
            cap_i[cap_n] = int'(out_i);
            cap_q[cap_n] = int'(out_q);
            cap_u[cap_n] = out_underflow;
            cap_n++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // step of tone idx per R4
    function automatic logic [31:0] step_of(int idx);
        longint n;
        longint d;
        n = longint'(2 * idx - 7) * 64'sd5000 * (longint'(1) << 32);
        d = n / 64'sd400000;
        return d[31:0];
    endfunction

    function automatic int ref_wave(logic [31:0] ph, bit want_cos);
        real ang;
        ang = 2.0 * PI * real'(int'(ph[31:22])) / 1024.0;
        if (want_cos) return $rtoi($floor(2047.0 * $cos(ang) + 0.5));
        return $rtoi($floor(2047.0 * $sin(ang) + 0.5));
    endfunction

    function automatic int absi(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic set_syms(input int n);
        nsyms = n;
        for (int s = 0; s < n; s++) begin
            // R1: first bit sent is the MSB of the tone index
            bit_buf[3*s]     = syms[s][2];
            bit_buf[3*s + 1] = syms[s][1];
            bit_buf[3*s + 2] = syms[s][0];
        end
    endtask

    task automatic start(input bit cont, input int sps);
        cap_on = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        cont_phase = cont;
        sps_cfg = 16'(sps);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cap_n = 0;
        cap_on = 1'b1;
        ready_low_seen = 0;
    endtask

    task automatic feed(input int first, input int cnt);
        int k;
        k = first;
        while (k < first + cnt) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = bit_buf[k];
            if (bit_ready) k++;
            else ready_low_seen++;
        end
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic drain(input int sps);
        int eff;
        eff = (sps == 0) ? 1 : sps;
        repeat (2 * eff + 12) @(negedge clk);
        cap_on = 1'b0;
    endtask

    task automatic analyze(input int sps, input bit cont, input bit gapless, input bit want_gap);
        int eff;
        int vcount;
        int first_v;
        int last_v;
        int gaps;
        int bad_idle;
        int sym_k;
        int pos;
        int ei;
        int eq;
        logic [31:0] ph;
        string tag;
        eff = (sps == 0) ? 1 : sps;
        vcount = 0; first_v = -1; last_v = -1; gaps = 0; bad_idle = 0;
        ph = 32'd0;
        for (int j = 0; j < cap_n; j++) begin
            if (cap_v[j]) begin
                sym_k = vcount / eff;
                pos   = vcount % eff;
                if (sym_k < nsyms) begin
                    if (pos == 0 && !cont) ph = 32'd0;
                    tag = (pos != 0) ? "R4" : (vcount == 0 ? "R6" : (cont ? "R6" : "R7"));
                    check(cap_t[j] == syms[sym_k], "R1", "tone index", cap_t[j], syms[sym_k]);
                    ei = ref_wave(ph, 1'b1);
                    eq = ref_wave(ph, 1'b0);
                    check(absi(cap_i[j] - ei) <= 1, "R5", "I sample", cap_i[j], ei);
                    check(absi(cap_q[j] - eq) <= 1, tag, "Q sample", cap_q[j], eq);
                    if (pos == 0 && !cont) begin
                        check(cap_i[j] == 2047 && cap_q[j] == 0, "R7", "split start I", cap_i[j], 2047);
                    end
                    ph = ph + step_of(syms[sym_k]);
                end
                vcount++;
                if (first_v < 0) first_v = j;
                last_v = j;
            end else begin
                if (!(cap_i[j] == 0 && cap_q[j] == 0 && cap_u[j])) bad_idle++;
            end
        end
        check(vcount == nsyms * eff, "R3", "valid sample count", vcount, nsyms * eff);
        check(bad_idle == 0, "R8", "idle samples not zero with flag", bad_idle, 0);
        for (int j = first_v; j >= 0 && j <= last_v; j++) begin
            if (!cap_v[j]) gaps++;
        end
        if (gapless) check(gaps == 0, "R10", "idle samples inside stream", gaps, 0);
        if (want_gap) check(gaps > 0, "R8", "underflow samples inside stream", gaps, 1);
    endtask

    task automatic scen_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9", "valid in reset", out_valid, 0);
        check(out_i == 0 && out_q == 0, "R9", "I in reset", out_i, 0);
        check(out_underflow == 1'b0, "R9", "underflow in reset", out_underflow, 0);
        check(bit_ready == 1'b1, "R9", "ready in reset", bit_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check(out_underflow == 1'b1, "R9", "underflow after reset", out_underflow, 1);
    endtask

    task automatic scen_all_tones();
        for (int s = 0; s < 16; s++) syms[s] = (s < 8) ? s : 15 - s;
        set_syms(16);
        start(1'b1, 6);
        feed(0, 48);
        drain(6);
        analyze(6, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic scen_split();
        syms[0] = 7; syms[1] = 0; syms[2] = 3; syms[3] = 3;
        syms[4] = 5; syms[5] = 1; syms[6] = 6; syms[7] = 2;
        set_syms(8);
        start(1'b0, 5);
        feed(0, 24);
        drain(5);
        analyze(5, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic scen_gap();
        syms[0] = 2; syms[1] = 6; syms[2] = 1; syms[3] = 4;
        set_syms(4);
        start(1'b1, 7);
        feed(0, 6);
        repeat (25) @(negedge clk);
        check(out_underflow == 1'b1 && out_i == 0, "R8", "starved output", out_i, 0);
        feed(6, 6);
        drain(7);
        analyze(7, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic scen_min_sps();
        syms[0] = 5; syms[1] = 5; syms[2] = 2; syms[3] = 7; syms[4] = 0; syms[5] = 3;
        set_syms(6);
        start(1'b1, 4);
        feed(0, 18);
        drain(4);
        analyze(4, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic scen_sps_zero();
        syms[0] = 1; syms[1] = 6; syms[2] = 3;
        set_syms(3);
        start(1'b1, 0);
        feed(0, 9);
        drain(0);
        analyze(0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic scen_ready();
        syms[0] = 4; syms[1] = 1; syms[2] = 7;
        set_syms(3);
        start(1'b0, 12);
        feed(0, 9);
        drain(12);
        check(ready_low_seen > 0, "R2", "cycles with ready low", ready_low_seen, 1);
        analyze(12, 1'b0, 1'b1, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog R10: actual %0d cycles expected completion before", 150000);
        finish_run();
    end

    initial begin
        scen_reset();
        scen_all_tones();
        scen_split();
        scen_gap();
        scen_min_sps();
        scen_sps_zero();
        scen_ready();
        finish_run();
    end

endmodule